// File: doc/BRIEF.md
# E1 Receive National Bit and Data-Link Extractor

This block sits behind an E1 receive framer that has already found frame and CRC-4 multiframe alignment. The framer presents each received channel-zero byte together with its frame number inside the multiframe (0 to 15). The block copies the five national bits Sa4 to Sa8 of every odd frame into a working store. At each multiframe start it moves the whole store into five readable bytes in a single cycle. Each readable byte holds one Sa bit position, gathered from the eight odd frames. A processor reads the bytes through a small address port. A sticky status flag, with a maskable interrupt, reports every multiframe start.

The block also turns one chosen Sa bit into a 4 kbit/s serial data link for an external HDLC controller. A free-running divider makes a square-wave link clock from the system clock. The divider is never re-timed by received frames, so a frame slip cannot shift its phase. Each received link bit is loaded on the falling edge of the link clock and then held for one full clock period. A slip can therefore only repeat a bit or drop one.

Two state machines carry the behaviour. The capture machine has two states. It starts in `CAP_HUNT`, where odd frames are not stored. On the first multiframe start it takes the transition ALIGN to `CAP_FILL`. In `CAP_FILL`, each further multiframe start takes the transition PUBLISH, which stays in `CAP_FILL` and copies the store into the readable bytes. The link-clock machine has two states. It alternates between `DL_LOW` and `DL_HIGH` every `HALF_DIV` cycles through the transitions RISE (`DL_LOW` to `DL_HIGH`) and FALL (`DL_HIGH` to `DL_LOW`). The link data is loaded on FALL.

Top module: `e1_natbit_rx`

## Requirements
- R1: After reset, all readable bytes read 0, and `mf_stat`, `irq`, `dl_clk` and `dl_data` are all 0.
- R2: Channel-zero bit 1 is `ts0_byte[7]` (MSB), so Sa4..Sa8 are `ts0_byte[4]..ts0_byte[0]`. For an odd frame n, Sa(4+k) is stored in bit (n-1)/2 of the byte at address k (k = 0..4). Addresses 5 to 7 read 0.
- R3: The readable bytes change only in the cycle after a frame-0 byte is received. Bits stored in the middle of a multiframe stay invisible until that point.
- R4: The first frame 0 after reset publishes nothing. Odd frames received before it are not stored.
- R5: Bytes of even frames reach neither the buffer nor the data link.
- R6: `mf_stat` sets in the cycle after every frame-0 byte, whatever the mask. A `stat_rd` pulse clears it. When a frame-0 byte and `stat_rd` arrive in the same cycle, the set wins.
- R7: `irq` is high exactly while `mf_stat` is high and `irq_mask` is low.
- R8: `dl_clk` starts low after reset and toggles every `HALF_DIV` cycles. Received frames never alter this timing.
- R9: `dl_data` changes only in the cycle where `dl_clk` falls. It then takes the link bit of the most recent odd frame and holds it for a full `dl_clk` period.
- R10: `dl_sel` bit k selects Sa(4+k) as the link bit. An all-zero `dl_sel` makes the link bit 0.
- R11: When no odd frame arrives within a link period, the previous link bit is repeated. When two arrive, only the later one is sent, and it is also the one kept in the buffer store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts0_valid | input | 1 | One-cycle strobe: a channel-zero byte is present |
| ts0_byte | input | 8 | Received channel-zero byte, bit 7 = bit 1 |
| mf_frame | input | 4 | Frame number of the byte within the CRC-4 multiframe |
| dl_sel | input | 5 | One-hot data-link Sa select, bit 0 = Sa4 |
| irq_mask | input | 1 | 1 masks the interrupt output |
| stat_rd | input | 1 | Status read strobe, clears `mf_stat` |
| buf_addr | input | 3 | Readable byte address |
| buf_data | output | 8 | Addressed national-bit byte |
| mf_stat | output | 1 | Multiframe-start status flag |
| irq | output | 1 | Multiframe-start interrupt, active high |
| dl_clk | output | 1 | 4 kHz data-link clock |
| dl_data | output | 1 | Serial data-link bit |

## Verification
The checker assertions cover the following on every cycle:
- the link clock toggles exactly every `HALF_DIV` cycles;
- `dl_data` moves only on a falling `dl_clk`;
- the published bytes stay frozen except after a frame-0 byte;
- the status sets and clears as required, and the interrupt stays off under the mask.

Only the bench scenarios can show that the right Sa bit lands in the right byte and bit position, and that even frames are ignored. The same holds for discarding the partial first multiframe, for the select word, and for the bit repeated or dropped by a slip. In those scenarios the bench predicts each link bit and each buffer byte from the channel-zero stream it sends.

// File: rtl/e1nb_pkg.sv
`timescale 1ns/1ps
package e1nb_pkg;
    localparam int SA_N   = 5;
    localparam int MF_LEN = 16;
    localparam int ODD_N  = MF_LEN / 2;
    localparam int FN_W   = $clog2(MF_LEN);
    localparam int IDX_W  = $clog2(ODD_N);
    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;

    typedef enum logic {CAP_HUNT, CAP_FILL} cap_state_t;
    typedef enum logic {DL_LOW, DL_HIGH}    dl_state_t;

    // Sa(4+k) sits at channel-zero bit 4+k, where bit 1 is the MSB.
    function automatic logic [SA_N-1:0] sa_of(input logic [BYTE_W-1:0] b);
        logic [SA_N-1:0] r;
        for (int k = 0; k < SA_N; k++) r[k] = b[BYTE_W-4-k];
        return r;
    endfunction
endpackage

// File: rtl/e1nb_capture.sv
`timescale 1ns/1ps
module e1nb_capture
    import e1nb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ts0_valid,
    input  logic [BYTE_W-1:0]      ts0_byte,
    input  logic [FN_W-1:0]        mf_frame,
    input  logic                   stat_rd,
    input  logic                   irq_mask,
    output logic [ODD_N-1:0]       pub [SA_N],
    output logic                   mf_stat,
    output logic                   irq
);
    cap_state_t        state_q, state_d;
    logic [ODD_N-1:0]  store_q [SA_N];
    logic [SA_N-1:0]   sa_now;
    logic [IDX_W-1:0]  slot;
    logic              odd_hit, mf_start;

    assign sa_now   = sa_of(ts0_byte);
    assign slot     = mf_frame[FN_W-1:1];
    assign odd_hit  = ts0_valid && mf_frame[0];
    assign mf_start = ts0_valid && (mf_frame == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_HUNT: if (mf_start) state_d = CAP_FILL;   // ALIGN
            CAP_FILL: state_d = CAP_FILL;                 // PUBLISH on mf_start
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CAP_HUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < SA_N; k++) begin
                store_q[k] <= '0;
                pub[k]     <= '0;
            end
            mf_stat <= 1'b0;
        end else begin
            if (state_q == CAP_FILL && odd_hit) begin
                for (int k = 0; k < SA_N; k++) store_q[k][slot] <= sa_now[k];
            end
            if (state_q == CAP_FILL && mf_start) begin
                for (int k = 0; k < SA_N; k++) pub[k] <= store_q[k];
            end
            if (mf_start)     mf_stat <= 1'b1;
            else if (stat_rd) mf_stat <= 1'b0;
        end
    end

    assign irq = mf_stat && !irq_mask;
endmodule

// File: rtl/e1nb_dlink.sv
`timescale 1ns/1ps
module e1nb_dlink
    import e1nb_pkg::*;
#(
    parameter int HALF_DIV = 25000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            odd_hit,
    input  logic [SA_N-1:0] sa_now,
    input  logic [SA_N-1:0] dl_sel,
    output logic            dl_clk,
    output logic            dl_data
);
    localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    dl_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          phase_end, fall, pend_q;

    assign phase_end = (cnt_q == LAST);
    assign fall      = (state_q == DL_HIGH) && phase_end;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DL_LOW:  if (phase_end) state_d = DL_HIGH;   // RISE
            DL_HIGH: if (phase_end) state_d = DL_LOW;    // FALL
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DL_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= phase_end ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            dl_data <= 1'b0;
        end else begin
            if (odd_hit) pend_q  <= |(sa_now & dl_sel);
            if (fall)    dl_data <= pend_q;
        end
    end

    assign dl_clk = (state_q == DL_HIGH);
endmodule

// File: rtl/e1nb_rdmux.sv
`timescale 1ns/1ps
module e1nb_rdmux
    import e1nb_pkg::*;
(
    input  logic [ODD_N-1:0]  pub [SA_N],
    input  logic [ADDR_W-1:0] buf_addr,
    output logic [BYTE_W-1:0] buf_data
);
    logic [BYTE_W-1:0] term [SA_N];

    for (genvar gk = 0; gk < SA_N; gk++) begin : g_term
        assign term[gk] = (buf_addr == ADDR_W'(gk)) ? BYTE_W'(pub[gk]) : '0;
    end

    always_comb begin
        buf_data = '0;
        for (int k = 0; k < SA_N; k++) buf_data = buf_data | term[k];
    end
endmodule

// File: rtl/e1_natbit_rx.sv
`timescale 1ns/1ps
module e1_natbit_rx
    import e1nb_pkg::*;
#(
    parameter int HALF_DIV = 25000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ts0_valid,
    input  logic [7:0]  ts0_byte,
    input  logic [3:0]  mf_frame,
    input  logic [4:0]  dl_sel,
    input  logic        irq_mask,
    input  logic        stat_rd,
    input  logic [2:0]  buf_addr,
    output logic [7:0]  buf_data,
    output logic        mf_stat,
    output logic        irq,
    output logic        dl_clk,
    output logic        dl_data
);
    logic [ODD_N-1:0]      pub [SA_N];
    logic [SA_N*ODD_N-1:0] pub_flat;

    e1nb_capture u_cap (
        .clk(clk), .rst_n(rst_n), .ts0_valid(ts0_valid), .ts0_byte(ts0_byte),
        .mf_frame(mf_frame), .stat_rd(stat_rd), .irq_mask(irq_mask),
        .pub(pub), .mf_stat(mf_stat), .irq(irq)
    );

    e1nb_dlink #(.HALF_DIV(HALF_DIV)) u_dl (
        .clk(clk), .rst_n(rst_n), .odd_hit(ts0_valid && mf_frame[0]),
        .sa_now(sa_of(ts0_byte)), .dl_sel(dl_sel),
        .dl_clk(dl_clk), .dl_data(dl_data)
    );

    e1nb_rdmux u_mux (.pub(pub), .buf_addr(buf_addr), .buf_data(buf_data));

    for (genvar gk = 0; gk < SA_N; gk++) begin : g_flat
        assign pub_flat[gk*ODD_N +: ODD_N] = pub[gk];
    end
endmodule

// File: rtl/e1_natbit_rx_chk.sv
`timescale 1ns/1ps
module e1_natbit_rx_chk #(
    parameter int HALF_DIV = 25000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ts0_valid,
    input logic [3:0]  mf_frame,
    input logic        stat_rd,
    input logic        irq_mask,
    input logic        mf_stat,
    input logic        irq,
    input logic        dl_clk,
    input logic        dl_data,
    input logic [39:0] pub_flat
);
    localparam int CW = $clog2(HALF_DIV + 1);
    localparam logic [CW-1:0] HW = CW'(HALF_DIV);

    logic [CW-1:0] tcnt;
    logic          clk_prev;
    logic          start;

    assign start = ts0_valid && (mf_frame == 4'd0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt     <= '0;
            clk_prev <= 1'b0;
        end else begin
            clk_prev <= dl_clk;
            tcnt     <= (dl_clk != clk_prev) ? CW'(1) : tcnt + 1'b1;
        end
    end

    // R8
    dl_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_clk != clk_prev) |-> (tcnt == HW));
    // R8
    dl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tcnt <= HW);
    // R9
    dl_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dl_data) |-> $fell(dl_clk));
    // R3
    pub_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(pub_flat));
    // R6
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> mf_stat);
    // R6
    stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !start) |=> !mf_stat);
    // R7
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq);
    // R7
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> mf_stat);
endmodule

bind e1_natbit_rx e1_natbit_rx_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .ts0_valid(ts0_valid), .mf_frame(mf_frame),
    .stat_rd(stat_rd), .irq_mask(irq_mask), .mf_stat(mf_stat), .irq(irq),
    .dl_clk(dl_clk), .dl_data(dl_data), .pub_flat(pub_flat)
);

// File: tb/tb_e1_natbit_rx.sv
`timescale 1ns/1ps
module tb_e1_natbit_rx;
    localparam int HALF = 20;

    logic clk = 0, rst_n = 0, ts0_valid = 0, irq_mask = 0, stat_rd = 0;
    logic [7:0] ts0_byte = '0;
    logic [3:0] mf_frame = '0;
    logic [4:0] dl_sel = 5'b00001;
    logic [2:0] buf_addr = '0;
    logic [7:0] buf_data;
    logic mf_stat, irq, dl_clk, dl_data;

    int checks = 0, errors = 0;
    logic exp_q[$];
    logic [7:0] exp_store [5];
    logic [7:0] exp_pub [5];
    bit aligned = 0;
    logic last_dl = 0;
    bit mon_on = 0;

    e1_natbit_rx #(.HALF_DIV(HALF)) dut (.*);

    always #2.5 clk = ~clk;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_byte(int fn, int seed);
        return 8'((fn * 53 + seed * 29 + 7) ^ (seed * 71));
    endfunction

    function automatic logic link_bit(logic [7:0] b, logic [4:0] sel);
        logic [4:0] s;
        for (int k = 0; k < 5; k++) s[k] = b[4-k];
        return |(s & sel);
    endfunction

    task automatic model_odd(int fn, logic [7:0] b);
        if (aligned) for (int k = 0; k < 5; k++) exp_store[k][(fn-1)/2] = b[4-k];
        last_dl = link_bit(b, dl_sel);
    endtask

    task automatic model_zero();
        if (aligned) for (int k = 0; k < 5; k++) exp_pub[k] = exp_store[k];
        aligned = 1;
    endtask

    task automatic wait_lvl(logic lvl);
        @(negedge clk);
        while (dl_clk == lvl) @(negedge clk);
        while (dl_clk != lvl) @(negedge clk);
    endtask

    task automatic pulse_ts0(int fn, logic [7:0] b, logic rd);
        ts0_valid = 1; mf_frame = 4'(fn); ts0_byte = b; stat_rd = rd;
        @(negedge clk);
        ts0_valid = 0; stat_rd = 0;
    endtask

    // driver: sends frames and pushes expected link bits
    task automatic run_frames(int first, int last, int seed, int slip_fn, int dup_fn);
        for (int f = first; f <= last; f++) begin
            int fn = f % 16;
            logic [7:0] b = mk_byte(fn, seed);
            wait_lvl(fn % 2 == 1);
            if (fn == slip_fn) begin
                exp_q.push_back(last_dl);
                continue;
            end
            if (fn == dup_fn) begin
                pulse_ts0(fn, ~b, 0);
                model_odd(fn, ~b);
                @(negedge clk);
            end
            pulse_ts0(fn, b, 0);
            if (fn % 2 == 1) begin
                model_odd(fn, b);
                exp_q.push_back(last_dl);
            end else if (fn == 0) model_zero();
        end
    endtask

    task automatic chk_buf(string tag);
        for (int a = 0; a < 8; a++) begin
            buf_addr = 3'(a);
            #1;
            check(tag, buf_data, (a < 5) ? exp_pub[a] : 0);
        end
    endtask

    // monitor: link clock period and link bits against the scoreboard
    initial begin
        int since = 0;
        bit have = 0;
        logic pc = 0, pd = 0;
        wait (mon_on);
        forever begin
            @(negedge clk);
            since++;
            if (pc && !dl_clk) begin
                if (have) check("R8 dl_clk period", since, 2 * HALF);
                have = 1; since = 0;
                if (exp_q.size() > 0) check("R9 R10 R11 dl_data", dl_data, exp_q.pop_front());
            end else if (dl_data !== pd) begin
                check("R9 dl_data moved off falling edge", 1, 0);
            end
            pc = dl_clk; pd = dl_data;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 5; k++) begin exp_store[k] = 0; exp_pub[k] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1;
        #1;
        check("R1 mf_stat", mf_stat, 0);
        check("R1 irq", irq, 0);
        check("R1 dl_clk", dl_clk, 0);
        check("R1 dl_data", dl_data, 0);
        chk_buf("R1 reset buffer");
        mon_on = 1;

        // partial multiframe then first frame 0: nothing published
        run_frames(8, 16, 1, -1, -1);
        chk_buf("R4 first frame 0");
        check("R6 status set", mf_stat, 1);
        check("R7 irq unmasked", irq, 1);
        @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0;
        check("R6 status cleared", mf_stat, 0);
        check("R7 irq cleared", irq, 0);

        // full multiframe, checked half way then at publish
        run_frames(1, 8, 2, -1, -1);
        chk_buf("R3 mid multiframe");
        run_frames(9, 16, 2, -1, -1);
        chk_buf("R2 R5 published bytes");

        // masked interrupt, select Sa6
        @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0;
        irq_mask = 1; dl_sel = 5'b00100;
        run_frames(1, 16, 3, -1, -1);
        check("R6 status under mask", mf_stat, 1);
        check("R7 irq masked", irq, 0);
        irq_mask = 0; #1;
        check("R7 irq unmasked", irq, 1);
        chk_buf("R2 Sa6 multiframe");

        // read coincident with frame 0, select Sa8
        @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0;
        dl_sel = 5'b10000;
        run_frames(1, 15, 4, -1, -1);
        wait_lvl(0);
        pulse_ts0(0, mk_byte(0, 4), 1);
        model_zero();
        check("R6 set wins over read", mf_stat, 1);
        chk_buf("R2 Sa8 multiframe");

        // slip (missing odd frame) and duplicated odd frame, select Sa5
        dl_sel = 5'b00010;
        run_frames(1, 16, 5, 5, 9);
        chk_buf("R11 slip and duplicate buffer");

        // empty select word
        dl_sel = 5'b00000;
        run_frames(1, 16, 6, -1, -1);
        chk_buf("R10 empty select buffer");

        repeat (8 * HALF) @(negedge clk);
        check("R9 scoreboard drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule